// File: doc/BRIEF.md
# Power Mode Transition Sequencer

The sequencer picks the processor's next operating mode when a sleep request arrives. There are four modes: active high-speed, active medium-speed, watch and subactive. On a request it samples five mode-control bits and a 3-bit wait field, then takes one of three routes:
- a direct change from high-speed to medium-speed;
- medium-speed to subactive, passing through watch;
- subactive to medium-speed, passing through watch and waiting there for a selectable time.

A request whose bits match no route leaves everything unchanged.

Each transition is timed in oscillator cycles, and the block runs on the oscillator clock. There are three phases. The entry phase covers the sleep and internal-processing states at the clock period of the old mode. An optional watch dwell follows. The exception phase covers the exception-handling states at the clock period of the new mode. The clock-divider select changes at the boundary into the exception phase. A one-cycle done pulse marks the end of exception entry.

Top module: `power_mode_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no request, mode_o is 0 (high-speed), div_sel_o is 0 and done_o is 0. The mode codes are high-speed 0, medium-speed 1, watch 2 and subactive 3. No other code ever appears.
- R2: In high-speed mode, a request with standby_i=0, low_speed_i=0, med_speed_i=1 and direct_i=1 moves mode_o straight from 0 to 1. Watch is never visited. The change occurs 6 cycles after the accepting edge, which is (2 sleep + 1 processing) states × 2 oscillator cycles.
- R3: The high-speed to medium-speed transition raises done_o 230 cycles after the accepting edge. That is 6 cycles plus 14 exception states × 16 cycles.
- R4: In medium-speed mode, a request with standby_i=1, low_speed_i=1, direct_i=1 and timer_src_i=1 sets mode_o to 2 after 48 cycles (3 × 16). One cycle later mode_o becomes 3, and done_o follows 896 cycles after that (14 × 64).
- R5: In subactive mode, a request with standby_i=1, low_speed_i=0, med_speed_i=1, direct_i=1 and timer_src_i=1 sets mode_o to 2 after 192 cycles (3 × 64). It then holds 2 for the wait time, then sets mode_o to 1. done_o follows 224 cycles after that.
- R6: The wait time of R5 is 8 << wait_sel_i oscillator cycles, so codes 0 to 7 give 8 to 1024 cycles.
- R7: A request whose bits match no route for the current mode changes neither mode_o nor div_sel_o and raises no done_o.
- R8: div_sel_o encodes the clock in use: 0 for high-speed (period 2), 1 for medium-speed (period 16), 2 for subactive (period 64). It changes only in the cycle where mode_o takes the target mode.
- R9: done_o is high for exactly one cycle per completed transition. While it is high, mode_o is 1 or 3 and is not changing.
- R10: Requests sampled on any edge from the accepting edge up to and including the edge that raises done_o are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Sleep request, sampled on each rising edge while idle |
| standby_i | input | 1 | Standby control bit |
| low_speed_i | input | 1 | Low-speed control bit |
| med_speed_i | input | 1 | Medium-speed control bit |
| direct_i | input | 1 | Direct-transfer control bit |
| timer_src_i | input | 1 | Timer clock-source control bit |
| wait_sel_i | input | 3 | Watch dwell select for the subactive exit |
| mode_o | output | 3 | Current mode code |
| div_sel_o | output | 2 | Clock-divider select |
| done_o | output | 1 | One-cycle pulse at end of exception entry |

## Verification
Two events can share a clock edge. One is the edge that closes the exception phase and raises done_o. The other is a new sleep request, possibly with bits that match a route. During every transition the bench drives random requests and control bits on each cycle, up to and including that final edge. It then demands that the mode, divider and done traces match the single expected transition, cycle for cycle. Any request that leaks into that edge, or into an earlier busy edge, shows up as a trace mismatch.

// File: rtl/pmts_pkg.sv
package pmts_pkg;

  typedef enum logic [2:0] {
    MODE_HIGH  = 3'd0,
    MODE_MED   = 3'd1,
    MODE_WATCH = 3'd2,
    MODE_SUB   = 3'd3
  } mode_e;

  typedef enum logic [1:0] {
    DIV_HS = 2'd0,
    DIV_MS = 2'd1,
    DIV_SB = 2'd2
  } div_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ENTRY,
    PH_DWELL,
    PH_EXC
  } phase_e;

  typedef struct packed {
    logic standby;
    logic low_speed;
    logic med_speed;
    logic direct;
    logic timer_src;
  } ctl_t;

  typedef struct packed {
    logic  hit;
    logic  via_watch;
    mode_e target;
    div_e  div_after;
  } route_t;

endpackage

// File: rtl/pmts_route.sv
module pmts_route
  import pmts_pkg::*;
#(
  parameter int SLEEP_ST   = 2,
  parameter int PROC_ST    = 1,
  parameter int EXC_ST     = 14,
  parameter int HS_PER     = 2,
  parameter int MS_PER     = 16,
  parameter int SB_PER     = 64,
  parameter int WAIT_BASE  = 8,
  parameter int WATCH_MIN  = 1,
  parameter int WAIT_SEL_W = 3,
  parameter int CNT_W      = 12
) (
  input  mode_e                  mode_i,
  input  ctl_t                   ctl_i,
  input  logic [WAIT_SEL_W-1:0]  wait_sel_i,
  output route_t                 route_o,
  output logic [CNT_W-1:0]       entry_len_o,
  output logic [CNT_W-1:0]       dwell_len_o,
  output logic [CNT_W-1:0]       exc_len_o
);

  localparam int WAIT_N   = 1 << WAIT_SEL_W;
  localparam int ENTRY_ST = SLEEP_ST + PROC_ST;

  localparam logic [CNT_W-1:0] HS_ENTRY = CNT_W'(ENTRY_ST * HS_PER);
  localparam logic [CNT_W-1:0] MS_ENTRY = CNT_W'(ENTRY_ST * MS_PER);
  localparam logic [CNT_W-1:0] SB_ENTRY = CNT_W'(ENTRY_ST * SB_PER);
  localparam logic [CNT_W-1:0] MS_EXC   = CNT_W'(EXC_ST * MS_PER);
  localparam logic [CNT_W-1:0] SB_EXC   = CNT_W'(EXC_ST * SB_PER);
  localparam logic [CNT_W-1:0] MIN_DW   = CNT_W'(WATCH_MIN);

  logic [CNT_W-1:0] wait_tab [WAIT_N];

  // dwell length doubles per code step
  for (genvar g = 0; g < WAIT_N; g++) begin : g_wait
    assign wait_tab[g] = CNT_W'(WAIT_BASE << g);
  end

  logic hs_to_ms, ms_to_sb, sb_to_ms;

  assign hs_to_ms = (mode_i == MODE_HIGH) && !ctl_i.standby && !ctl_i.low_speed &&
                    ctl_i.med_speed && ctl_i.direct;
  assign ms_to_sb = (mode_i == MODE_MED) && ctl_i.standby && ctl_i.low_speed &&
                    ctl_i.direct && ctl_i.timer_src;
  assign sb_to_ms = (mode_i == MODE_SUB) && ctl_i.standby && !ctl_i.low_speed &&
                    ctl_i.med_speed && ctl_i.direct && ctl_i.timer_src;

  always_comb begin
    route_o           = '0;
    route_o.target    = mode_i;
    route_o.div_after = DIV_HS;
    entry_len_o       = '0;
    dwell_len_o       = '0;
    exc_len_o         = '0;
    if (hs_to_ms) begin
      route_o.hit       = 1'b1;
      route_o.target    = MODE_MED;
      route_o.div_after = DIV_MS;
      entry_len_o       = HS_ENTRY;
      exc_len_o         = MS_EXC;
    end else if (ms_to_sb) begin
      route_o.hit       = 1'b1;
      route_o.via_watch = 1'b1;
      route_o.target    = MODE_SUB;
      route_o.div_after = DIV_SB;
      entry_len_o       = MS_ENTRY;
      dwell_len_o       = MIN_DW;
      exc_len_o         = SB_EXC;
    end else if (sb_to_ms) begin
      route_o.hit       = 1'b1;
      route_o.via_watch = 1'b1;
      route_o.target    = MODE_MED;
      route_o.div_after = DIV_MS;
      entry_len_o       = SB_ENTRY;
      dwell_len_o       = wait_tab[wait_sel_i];
      exc_len_o         = MS_EXC;
    end
  end

endmodule

// File: rtl/pmts_counter.sv
module pmts_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pmts_fsm.sv
module pmts_fsm
  import pmts_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  route_t           route_i,
  input  logic [CNT_W-1:0] entry_len_i,
  input  logic [CNT_W-1:0] dwell_len_i,
  input  logic [CNT_W-1:0] exc_len_i,
  input  logic             cnt_zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output mode_e            mode_o,
  output div_e             div_o,
  output logic             done_o
);

  phase_e           phase_q, phase_d;
  mode_e            mode_q, mode_d;
  mode_e            tgt_q, tgt_d;
  div_e             div_q, div_d;
  div_e             div_after_q, div_after_d;
  logic             via_q, via_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] dwell_q, dwell_d;
  logic [CNT_W-1:0] exc_q, exc_d;

  always_comb begin
    phase_d     = phase_q;
    mode_d      = mode_q;
    tgt_d       = tgt_q;
    div_d       = div_q;
    div_after_d = div_after_q;
    via_d       = via_q;
    dwell_d     = dwell_q;
    exc_d       = exc_q;
    done_d      = 1'b0;
    load_o      = 1'b0;
    load_val_o  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (sleep_req_i && route_i.hit) begin
          phase_d     = PH_ENTRY;
          tgt_d       = route_i.target;
          div_after_d = route_i.div_after;
          via_d       = route_i.via_watch;
          dwell_d     = dwell_len_i;
          exc_d       = exc_len_i;
          load_o      = 1'b1;
          load_val_o  = entry_len_i - 1'b1;
        end
      end
      PH_ENTRY: begin
        if (cnt_zero_i) begin
          load_o = 1'b1;
          if (via_q) begin
            phase_d    = PH_DWELL;
            mode_d     = MODE_WATCH;
            load_val_o = dwell_q - 1'b1;
          end else begin
            phase_d    = PH_EXC;
            mode_d     = tgt_q;
            div_d      = div_after_q;
            load_val_o = exc_q - 1'b1;
          end
        end
      end
      PH_DWELL: begin
        if (cnt_zero_i) begin
          phase_d    = PH_EXC;
          mode_d     = tgt_q;
          div_d      = div_after_q;
          load_o     = 1'b1;
          load_val_o = exc_q - 1'b1;
        end
      end
      PH_EXC: begin
        if (cnt_zero_i) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      mode_q      <= MODE_HIGH;
      tgt_q       <= MODE_HIGH;
      div_q       <= DIV_HS;
      div_after_q <= DIV_HS;
      via_q       <= 1'b0;
      done_q      <= 1'b0;
      dwell_q     <= '0;
      exc_q       <= '0;
    end else begin
      phase_q     <= phase_d;
      mode_q      <= mode_d;
      tgt_q       <= tgt_d;
      div_q       <= div_d;
      div_after_q <= div_after_d;
      via_q       <= via_d;
      done_q      <= done_d;
      dwell_q     <= dwell_d;
      exc_q       <= exc_d;
    end
  end

  assign mode_o = mode_q;
  assign div_o  = div_q;
  assign done_o = done_q;

endmodule

// File: rtl/power_mode_seq.sv
module power_mode_seq
  import pmts_pkg::*;
#(
  parameter int SLEEP_ST   = 2,
  parameter int PROC_ST    = 1,
  parameter int EXC_ST     = 14,
  parameter int HS_PER     = 2,
  parameter int MS_PER     = 16,
  parameter int SB_PER     = 64,
  parameter int WAIT_BASE  = 8,
  parameter int WATCH_MIN  = 1,
  parameter int WAIT_SEL_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sleep_req_i,
  input  logic                  standby_i,
  input  logic                  low_speed_i,
  input  logic                  med_speed_i,
  input  logic                  direct_i,
  input  logic                  timer_src_i,
  input  logic [WAIT_SEL_W-1:0] wait_sel_i,
  output logic [2:0]            mode_o,
  output logic [1:0]            div_sel_o,
  output logic                  done_o
);

  localparam int MAX_DWELL = WAIT_BASE << ((1 << WAIT_SEL_W) - 1);
  localparam int LONGEST   = (SLEEP_ST + PROC_ST + EXC_ST) * (HS_PER + MS_PER + SB_PER)
                             + MAX_DWELL + WATCH_MIN;
  localparam int CNT_W     = $clog2(LONGEST + 1);

  ctl_t             ctl;
  route_t           route;
  mode_e            mode;
  div_e             div;
  logic [CNT_W-1:0] entry_len, dwell_len, exc_len, load_val;
  logic             load, cnt_zero;

  assign ctl = '{standby:   standby_i,
                 low_speed: low_speed_i,
                 med_speed: med_speed_i,
                 direct:    direct_i,
                 timer_src: timer_src_i};

  pmts_route #(
    .SLEEP_ST  (SLEEP_ST),
    .PROC_ST   (PROC_ST),
    .EXC_ST    (EXC_ST),
    .HS_PER    (HS_PER),
    .MS_PER    (MS_PER),
    .SB_PER    (SB_PER),
    .WAIT_BASE (WAIT_BASE),
    .WATCH_MIN (WATCH_MIN),
    .WAIT_SEL_W(WAIT_SEL_W),
    .CNT_W     (CNT_W)
  ) u_route (
    .mode_i     (mode),
    .ctl_i      (ctl),
    .wait_sel_i (wait_sel_i),
    .route_o    (route),
    .entry_len_o(entry_len),
    .dwell_len_o(dwell_len),
    .exc_len_o  (exc_len)
  );

  pmts_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req_i),
    .route_i    (route),
    .entry_len_i(entry_len),
    .dwell_len_i(dwell_len),
    .exc_len_i  (exc_len),
    .cnt_zero_i (cnt_zero),
    .load_o     (load),
    .load_val_o (load_val),
    .mode_o     (mode),
    .div_o      (div),
    .done_o     (done_o)
  );

  pmts_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (cnt_zero)
  );

  assign mode_o    = mode;
  assign div_sel_o = div;

endmodule

// File: rtl/power_mode_seq_chk.sv
module power_mode_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_o,
  input logic [1:0] div_sel_o,
  input logic       done_o
);

  // R1
  mode_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd3);

  // R2
  high_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 3'd0 && mode_o != 3'd0) |-> mode_o == 3'd1);

  // R4
  watch_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 && $past(mode_o) != 3'd2) |-> ($past(mode_o) == 3'd1 || $past(mode_o) == 3'd3));

  // R5
  watch_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 3'd2 && mode_o != 3'd2) |-> (mode_o == 3'd1 || mode_o == 3'd3));

  // R8
  div_with_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_sel_o) |-> !$stable(mode_o));

  // R8
  div_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_sel_o != 2'd3);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((mode_o == 3'd1 || mode_o == 3'd3) && $stable(mode_o)));

endmodule

bind power_mode_seq power_mode_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_o   (mode_o),
  .div_sel_o(div_sel_o),
  .done_o   (done_o)
);

// File: tb/power_mode_seq_bench.sv
module power_mode_seq_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sleep_req_i = 1'b0;
  logic       standby_i = 1'b0, low_speed_i = 1'b0, med_speed_i = 1'b0;
  logic       direct_i = 1'b0, timer_src_i = 1'b0;
  logic [2:0] wait_sel_i = 3'd0;
  logic [2:0] mode_o;
  logic [1:0] div_sel_o;
  logic       done_o;

  int checks = 0;
  int failures = 0;
  int exp_mode = 0;
  int exp_div = 0;

  always #10 clk_i = ~clk_i;

  power_mode_seq u_power_mode_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req_i),
    .standby_i  (standby_i),
    .low_speed_i(low_speed_i),
    .med_speed_i(med_speed_i),
    .direct_i   (direct_i),
    .timer_src_i(timer_src_i),
    .wait_sel_i (wait_sel_i),
    .mode_o     (mode_o),
    .div_sel_o  (div_sel_o),
    .done_o     (done_o)
  );

  // c = {standby, low_speed, med_speed, direct, timer_src}
  function automatic void plan(input int m, input logic [4:0] c, input logic [2:0] ws,
                               output bit hit, output bit via, output int tgt, output int pre,
                               output int wt, output int post, output int dva);
    hit = 0; via = 0; tgt = m; pre = 0; wt = 0; post = 0; dva = 0;
    if (m == 0 && !c[4] && !c[3] && c[2] && c[1]) begin
      hit = 1; tgt = 1; pre = 6; post = 224; dva = 1;
    end else if (m == 1 && c[4] && c[3] && c[1] && c[0]) begin
      hit = 1; via = 1; tgt = 3; pre = 48; wt = 1; post = 896; dva = 2;
    end else if (m == 3 && c[4] && !c[3] && c[2] && c[1] && c[0]) begin
      hit = 1; via = 1; tgt = 1; pre = 192; wt = 8 << ws; post = 224; dva = 1;
    end
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [4:0] c, input logic [2:0] ws);
    {standby_i, low_speed_i, med_speed_i, direct_i, timer_src_i} = c;
    wait_sel_i = ws;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    sleep_req_i = 1'b0;
    @(negedge clk_i);
    // R1 outputs during reset
    check("R1 mode in reset", mode_o, 0);
    check("R1 div in reset", div_sel_o, 0);
    check("R1 done in reset", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 mode after reset", mode_o, 0);
    exp_mode = 0;
    exp_div = 0;
  endtask

  task automatic run_req(input logic [4:0] c, input logic [2:0] ws, input bit noise);
    bit hit, via;
    int tgt, pre, wt, post, dva, len;
    int bad_m, bad_d, bad_n, am, em, ad, ed, an, en, km, kd, kn;
    string tag;
    plan(exp_mode, c, ws, hit, via, tgt, pre, wt, post, dva);
    @(negedge clk_i);
    set_ctl(c, ws);
    sleep_req_i = 1'b1;
    @(negedge clk_i);
    sleep_req_i = 1'b0;
    if (!hit) begin
      bad_m = 0; bad_n = 0;
      for (int k = 0; k < 6; k++) begin
        if (mode_o != exp_mode || div_sel_o != exp_div) bad_m++;
        if (done_o) bad_n++;
        @(negedge clk_i);
      end
      // R7 unmatched request has no effect
      check("R7 unmatched request changed mode/div (count)", bad_m, 0);
      check("R7 unmatched request raised done (count)", bad_n, 0);
      return;
    end
    len = pre + wt + post;
    bad_m = 0; bad_d = 0; bad_n = 0;
    am = 0; em = 0; ad = 0; ed = 0; an = 0; en = 0; km = 0; kd = 0; kn = 0;
    for (int k = 0; k <= len + 1; k++) begin
      int xm, xd, xn;
      if (k < pre) xm = exp_mode;
      else if (via && k < pre + wt) xm = 2;
      else xm = tgt;
      xd = (k < pre + wt) ? exp_div : dva;
      xn = (k == len) ? 1 : 0;
      if (mode_o != xm) begin if (bad_m == 0) begin am = mode_o; em = xm; km = k; end bad_m++; end
      if (div_sel_o != xd) begin if (bad_d == 0) begin ad = div_sel_o; ed = xd; kd = k; end bad_d++; end
      if (done_o != xn) begin if (bad_n == 0) begin an = done_o; en = xn; kn = k; end bad_n++; end
      // R10 requests up to the done edge are ignored
      if (noise && k < len) begin
        sleep_req_i = 1'($urandom);
        set_ctl(5'($urandom), 3'($urandom));
        if ($urandom % 4 == 0) set_ctl(5'b11111, 3'($urandom));
      end else begin
        sleep_req_i = 1'b0;
      end
      @(negedge clk_i);
    end
    sleep_req_i = 1'b0;
    if (exp_mode == 0) tag = "R2";
    else if (exp_mode == 1) tag = "R4";
    else tag = "R5 R6";
    if (noise) tag = {tag, " R10"};
    checks++;
    if (bad_m != 0) begin
      failures++;
      $display("FAIL %s mode at k=%0d actual=%0d expected=%0d", tag, km, am, em);
    end
    checks++;
    if (bad_d != 0) begin
      failures++;
      $display("FAIL R8 %s div at k=%0d actual=%0d expected=%0d", tag, kd, ad, ed);
    end
    checks++;
    if (bad_n != 0) begin
      failures++;
      $display("FAIL R3 R9 %s done at k=%0d actual=%0d expected=%0d (len %0d)", tag, kn, an, en, len);
    end
    exp_mode = tgt;
    exp_div = dva;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check("R1 mode reset", mode_o, 0);
    check("R1 div reset", div_sel_o, 0);
    check("R1 done reset", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7 near misses in high-speed mode
    run_req(5'b10110, 3'd0, 0);
    run_req(5'b01110, 3'd0, 0);
    run_req(5'b00100, 3'd0, 0);
    // R2 R3 direct speed change
    run_req(5'b00110, 3'd0, 0);
    // R7 near misses in medium-speed mode
    run_req(5'b11001, 3'd0, 0);
    run_req(5'b00111, 3'd0, 0);
    // R4 into subactive
    run_req(5'b11011, 3'd0, 0);
    // R7 near miss in subactive
    run_req(5'b11111, 3'd0, 0);
    // R5 R6 shortest dwell
    run_req(5'b10111, 3'd0, 0);
    run_req(5'b11011, 3'd5, 1);
    // R5 R6 longest dwell
    run_req(5'b10111, 3'd7, 1);
    do_reset();
    run_req(5'b00111, 3'd2, 1);
    for (int i = 0; i < 30; i++) begin
      logic [4:0] c;
      if ($urandom % 8 == 0) begin
        do_reset();
      end else begin
        c = 5'($urandom);
        if ($urandom % 2 == 0) begin
          if (exp_mode == 0) c = {3'b001, 1'b1, 1'($urandom)};
          else if (exp_mode == 1) c = {2'b11, 1'($urandom), 2'b11};
          else c = 5'b10111;
        end
        run_req(c, 3'($urandom), 1'($urandom));
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule